// File: doc/BRIEF.md
# Tunable Two-Pole Bandpass Resonator

This block is a streaming second-order recursive filter placed between an analog-to-digital converter and a digital-to-analog converter. It has two poles and one zero at the origin, so each new output depends on the previous input sample and the two previous outputs. The centre of the passband moves at run time: two pushbuttons step an index through a small table of pole coefficient pairs, from the lowest centre frequency (index 0) up to the highest (index 7).

A free-running divider produces a single-cycle sample strobe and a square converter clock at the same rate. Every filter update, input capture and output change happens on the strobe edge. Coefficients are signed fixed-point values with 14 fractional bits. The two output history registers are 24 bits wide, which gives them 12 more fractional bits than the 12-bit samples at the edge. Button inputs are synchronized and debounced inside the block. A newly selected coefficient pair is held back until the next sample boundary.

Top module: `bpf_tunable`

## Requirements
- R1: `sample_stb` is high for exactly one clock in every `SAMPLE_DIV` clocks. It is high first on the `SAMPLE_DIV`-th clock after reset is released. `conv_clk` is high during the first `SAMPLE_DIV/2` clocks of each period and rises on the clock after each strobe.
- R2: At each strobe edge, the new state is `y = floor((B·x_d·2^12 + a1·y1 + a2·y2) / 2^14)`. The state is held in units of 2^-12 of an output LSB, and `x_d` is the `din` value captured at the previous strobe edge. At the same edge, `y2` takes `y1`, `y1` takes `y`, and `x_d` takes the current `din`.
- R3: When the shifted sum lies outside the signed 24-bit range, the state saturates to the nearest bound (+8388607 or -8388608). It never wraps.
- R4: At each strobe edge, `dout` becomes `floor((y + 2048) / 4096)` clamped to [-2048, 2047]. Between strobes, `dout` holds its value.
- R5: Coefficients are signed Q2.14. `B` = 1984 and `a2` = -14400 for every index. `a1` for indices 0 to 7 is 28000, 24000, 18000, 11000, 3000, -6000, -15000, -24000.
- R6: An accepted press of `btn_up` raises the pending index by one, stopping at 7. An accepted press of `btn_dn` lowers it by one, stopping at 0. Presses accepted in the same clock cancel each other.
- R7: Each button passes through two synchronizer flops. A synchronized level that differs from the accepted level for `DEB_CYCLES` consecutive clocks becomes the accepted level. Acceptance of a high level makes one step pulse on the next clock. Shorter glitches and releases make no step.
- R8: `band_idx` shows the coefficient index in use. It changes only at a strobe edge, where it takes the pending index.
- R9: Synchronous reset clears `x_d`, both states, `dout`, both indices, the debouncers and the divider. While in reset, `conv_clk` reads 1 and `sample_stb` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Signed converter sample, captured at the strobe edge |
| btn_up | input | 1 | Raw pushbutton, raises centre frequency |
| btn_dn | input | 1 | Raw pushbutton, lowers centre frequency |
| conv_clk | output | 1 | Converter clock at the sample rate |
| sample_stb | output | 1 | One-clock pulse marking each sample boundary |
| dout | output | DATA_W | Signed filtered, rounded, saturated sample |
| band_idx | output | 3 | Coefficient index currently applied |

## Verification
`dout`, `band_idx`, `sample_stb` and `conv_clk` are all registered. Each is due on the clock edge that ends the strobe cycle, and `conv_clk` is due on the edge after a wrap. A button press reaches the pending index `DEB_CYCLES + 3` clocks after the raw level first reaches the synchronizer, and reaches `band_idx` only at the next strobe edge. The bench model advances on the same rising edge as the design and counts those registers stage by stage. Outputs are compared on the falling edge of every clock, so each result is sampled in the cycle it becomes valid.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;
    localparam int N_BANDS   = 8;
    localparam int IDX_W     = $clog2(N_BANDS);

    typedef logic signed [COEF_W-1:0] coef_t;

    localparam coef_t B_COEF  = 16'sd1984;
    localparam coef_t A2_COEF = -16'sd14400;

    // pole-pair feedback term; index 0 sits lowest in frequency
    function automatic coef_t band_a1(input logic [IDX_W-1:0] k);
        case (k)
            3'd0:    return 16'sd28000;
            3'd1:    return 16'sd24000;
            3'd2:    return 16'sd18000;
            3'd3:    return 16'sd11000;
            3'd4:    return 16'sd3000;
            3'd5:    return -16'sd6000;
            3'd6:    return -16'sd15000;
            default: return -16'sd24000;
        endcase
    endfunction
endpackage

// File: rtl/bpf_debounce.sv
module bpf_debounce #(
    parameter int DEB_CYCLES = 65535
) (
    input  logic clk,
    input  logic rst,
    input  logic btn,
    output logic press
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          stable;
        logic [CW-1:0] cnt;
        logic          press;
    } deb_t;

    deb_t deb_d, deb_q;

    always_comb begin
        deb_d       = deb_q;
        deb_d.sync  = {deb_q.sync[0], btn};
        deb_d.press = 1'b0;
        if (deb_q.sync[1] != deb_q.stable) begin
            if (deb_q.cnt == CW'(DEB_CYCLES - 1)) begin
                deb_d.stable = deb_q.sync[1];
                deb_d.cnt    = '0;
                deb_d.press  = deb_q.sync[1];
            end else begin
                deb_d.cnt = deb_q.cnt + 1'b1;
            end
        end else begin
            deb_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) deb_q <= '0;
        else     deb_q <= deb_d;
    end

    assign press = deb_q.press;
endmodule

// File: rtl/bpf_band_sel.sv
module bpf_band_sel
    import bpf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             stb,
    output coef_t            a1,
    output coef_t            a2,
    output logic [IDX_W-1:0] band
);
    typedef struct packed {
        logic [IDX_W-1:0] pend;
        logic [IDX_W-1:0] act;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (step_up && !step_dn && sel_q.pend != IDX_W'(N_BANDS - 1))
            sel_d.pend = sel_q.pend + 1'b1;
        else if (step_dn && !step_up && sel_q.pend != '0)
            sel_d.pend = sel_q.pend - 1'b1;
        if (stb)
            sel_d.act = sel_q.pend;
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= sel_d;
    end

    assign a1   = band_a1(sel_q.act);
    assign a2   = A2_COEF;
    assign band = sel_q.act;
endmodule

// File: rtl/bpf_datapath.sv
module bpf_datapath
    import bpf_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int STATE_W = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stb,
    input  logic signed [DATA_W-1:0] din,
    input  coef_t                    a1,
    input  coef_t                    a2,
    output logic signed [DATA_W-1:0] dout
);
    localparam int FRAC_X = STATE_W - DATA_W;
    localparam int PB_W   = COEF_W + DATA_W;
    localparam int PY_W   = COEF_W + STATE_W;
    localparam int ACC_W  = PY_W + 2;

    localparam logic signed [ACC_W-1:0] S_MAX_A =
        {{(ACC_W-STATE_W+1){1'b0}}, {(STATE_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] S_MIN_A =
        {{(ACC_W-STATE_W+1){1'b1}}, {(STATE_W-1){1'b0}}};
    localparam logic signed [STATE_W-1:0] Y_MAX = {1'b0, {(STATE_W-1){1'b1}}};
    localparam logic signed [STATE_W-1:0] Y_MIN = {1'b1, {(STATE_W-1){1'b0}}};
    localparam logic signed [STATE_W:0] HALF_R =
        {{(STATE_W-FRAC_X+1){1'b0}}, 1'b1, {(FRAC_X-1){1'b0}}};
    localparam logic signed [STATE_W:0] O_MAX =
        {{(STATE_W-DATA_W+2){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [STATE_W:0] O_MIN =
        {{(STATE_W-DATA_W+2){1'b1}}, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic signed [DATA_W-1:0]  x_d;
        logic signed [STATE_W-1:0] y1;
        logic signed [STATE_W-1:0] y2;
        logic signed [DATA_W-1:0]  out;
    } dp_t;

    dp_t dp_d, dp_q;

    logic signed [PB_W-1:0]    prod_b;
    logic signed [PY_W-1:0]    prod_1, prod_2;
    logic signed [ACC_W-1:0]   acc, acc_sh;
    logic signed [STATE_W-1:0] y_new;
    logic signed [STATE_W:0]   rnd, rnd_sh;
    logic signed [DATA_W-1:0]  o_new;

    always_comb begin
        prod_b = PB_W'(B_COEF) * PB_W'(dp_q.x_d);
        prod_1 = PY_W'(a1) * PY_W'(dp_q.y1);
        prod_2 = PY_W'(a2) * PY_W'(dp_q.y2);
        acc    = (ACC_W'(prod_b) <<< FRAC_X) + ACC_W'(prod_1) + ACC_W'(prod_2);
        acc_sh = acc >>> COEF_FRAC;

        if (acc_sh > S_MAX_A)      y_new = Y_MAX;
        else if (acc_sh < S_MIN_A) y_new = Y_MIN;
        else                       y_new = STATE_W'(acc_sh);

        rnd    = {y_new[STATE_W-1], y_new} + HALF_R;
        rnd_sh = rnd >>> FRAC_X;
        if (rnd_sh > O_MAX)      o_new = O_MAX[DATA_W-1:0];
        else if (rnd_sh < O_MIN) o_new = O_MIN[DATA_W-1:0];
        else                     o_new = DATA_W'(rnd_sh);

        dp_d = dp_q;
        if (stb) begin
            dp_d.x_d = din;
            dp_d.y1  = y_new;
            dp_d.y2  = dp_q.y1;
            dp_d.out = o_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign dout = dp_q.out;
endmodule

// File: rtl/bpf_tunable.sv
module bpf_tunable
    import bpf_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int STATE_W    = 24,
    parameter int SAMPLE_DIV = 64,
    parameter int DEB_CYCLES = 65535
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] din,
    input  logic                     btn_up,
    input  logic                     btn_dn,
    output logic                     conv_clk,
    output logic                     sample_stb,
    output logic signed [DATA_W-1:0] dout,
    output logic [IDX_W-1:0]         band_idx
);
    localparam int CNT_W = $clog2(SAMPLE_DIV);
    localparam int N_BTN = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             cclk;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == CNT_W'(SAMPLE_DIV - 1)) tmr_d.cnt = '0;
        else                                    tmr_d.cnt = tmr_q.cnt + 1'b1;
        tmr_d.cclk = (tmr_d.cnt < CNT_W'(SAMPLE_DIV / 2));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q.cnt  <= '0;
            tmr_q.cclk <= 1'b1;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign sample_stb = (tmr_q.cnt == CNT_W'(SAMPLE_DIV - 1));
    assign conv_clk   = tmr_q.cclk;

    logic [N_BTN-1:0] raw_btn, step;
    assign raw_btn = {btn_dn, btn_up};

    for (genvar i = 0; i < N_BTN; i++) begin : g_btn
        bpf_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
            .clk   (clk),
            .rst   (rst),
            .btn   (raw_btn[i]),
            .press (step[i])
        );
    end

    coef_t a1_w, a2_w;

    bpf_band_sel u_sel (
        .clk     (clk),
        .rst     (rst),
        .step_up (step[0]),
        .step_dn (step[1]),
        .stb     (sample_stb),
        .a1      (a1_w),
        .a2      (a2_w),
        .band    (band_idx)
    );

    bpf_datapath #(.DATA_W(DATA_W), .STATE_W(STATE_W)) u_dp (
        .clk  (clk),
        .rst  (rst),
        .stb  (sample_stb),
        .din  (din),
        .a1   (a1_w),
        .a2   (a2_w),
        .dout (dout)
    );
endmodule

// File: rtl/bpf_tunable_chk.sv
module bpf_tunable_chk #(
    parameter int DATA_W     = 12,
    parameter int IDX_W      = 3,
    parameter int SAMPLE_DIV = 64
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     sample_stb,
    input logic                     conv_clk,
    input logic signed [DATA_W-1:0] dout,
    input logic [IDX_W-1:0]         band_idx
);
    localparam int GW = $clog2(SAMPLE_DIV) + 1;

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || sample_stb) gap_q <= '0;
        else                   gap_q <= gap_q + 1'b1;
    end

    // R1: strobe exactly when SAMPLE_DIV-1 idle clocks have elapsed
    p_stb_period_r1: assert property (@(posedge clk) disable iff (rst)
        sample_stb == (gap_q == GW'(SAMPLE_DIV - 1)));

    p_stb_single_r1: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

    p_conv_rise_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(conv_clk)) |-> $past(sample_stb));

    p_dout_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> $stable(dout));

    p_band_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> $stable(band_idx));
endmodule

bind bpf_tunable bpf_tunable_chk #(
    .DATA_W     (DATA_W),
    .IDX_W      (bpf_pkg::IDX_W),
    .SAMPLE_DIV (SAMPLE_DIV)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_stb (sample_stb),
    .conv_clk   (conv_clk),
    .dout       (dout),
    .band_idx   (band_idx)
);

// File: tb/tb_bpf_tunable.sv
`timescale 1ns/1ps
module tb_bpf_tunable;
    localparam int DW  = 12;
    localparam int DIV = 16;
    localparam int DEB = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [DW-1:0] din = '0;
    logic btn_up = 1'b0, btn_dn = 1'b0;
    logic conv_clk, sample_stb;
    logic signed [DW-1:0] dout;
    logic [2:0] band_idx;

    always #2 clk = ~clk;

    bpf_tunable #(.DATA_W(DW), .STATE_W(24), .SAMPLE_DIV(DIV), .DEB_CYCLES(DEB)) dut (
        .clk(clk), .rst(rst), .din(din), .btn_up(btn_up), .btn_dn(btn_dn),
        .conv_clk(conv_clk), .sample_stb(sample_stb), .dout(dout), .band_idx(band_idx)
    );

    int n_chk = 0, n_err = 0, rails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int     A1 [8] = '{28000, 24000, 18000, 11000, 3000, -6000, -15000, -24000};
    int     m_cnt = 0, m_pend = 0, m_act = 0, m_out = 0;
    longint m_xd = 0, m_y1 = 0, m_y2 = 0;
    int     m_s0 [2] = '{0, 0}, m_s1 [2] = '{0, 0}, m_st [2] = '{0, 0}, m_dc [2] = '{0, 0};
    int     m_pr [2] = '{0, 0};

    always @(posedge clk) begin : model
        int     raw [2];
        int     np;
        longint acc, y, o;
        raw[0] = btn_up;
        raw[1] = btn_dn;
        if (rst) begin
            m_cnt = 0; m_pend = 0; m_act = 0; m_out = 0;
            m_xd = 0; m_y1 = 0; m_y2 = 0;
            for (int b = 0; b < 2; b++) begin
                m_s0[b] = 0; m_s1[b] = 0; m_st[b] = 0; m_dc[b] = 0; m_pr[b] = 0;
            end
        end else begin
            if (m_cnt == DIV - 1) begin
                acc = 1984 * m_xd * 4096 + A1[m_act] * m_y1 - 14400 * m_y2;
                y = acc >>> 14;
                if (y > 8388607) y = 8388607;
                if (y < -8388608) y = -8388608;
                o = (y + 2048) >>> 12;
                if (o > 2047) o = 2047;
                if (o < -2048) o = -2048;
                m_y2 = m_y1; m_y1 = y; m_xd = longint'(din); m_out = int'(o);
                m_act = m_pend;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            if (m_pr[0] == 1 && m_pr[1] == 0 && m_pend < 7) m_pend++;
            else if (m_pr[1] == 1 && m_pr[0] == 0 && m_pend > 0) m_pend--;
            for (int b = 0; b < 2; b++) begin
                np = 0;
                if (m_s1[b] != m_st[b]) begin
                    if (m_dc[b] == DEB - 1) begin
                        m_st[b] = m_s1[b]; m_dc[b] = 0; np = m_s1[b];
                    end else m_dc[b]++;
                end else m_dc[b] = 0;
                m_s1[b] = m_s0[b];
                m_s0[b] = raw[b];
                m_pr[b] = np;
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk(sample_stb == (m_cnt == DIV - 1), "R1 sample_stb", sample_stb, m_cnt == DIV - 1);
            chk(conv_clk == (m_cnt < DIV / 2), "R1 conv_clk", conv_clk, m_cnt < DIV / 2);
            chk(int'(dout) == m_out, "R2/R4/R5 dout", dout, m_out);
            chk(int'(band_idx) == m_act, "R8 band_idx", band_idx, m_act);
            if (dout == 12'sd2047 || dout == -12'sd2048) rails++;
        end
    end

    // ---------------- stimulus ----------------
    int mode = 0;  // 0 zero, 1 impulses, 2 square near band 0 centre, 3 noise
    int t = 0;
    always @(negedge clk) begin
        t++;
        case (mode)
            1:       din <= ((t % (64 * DIV)) < DIV) ? 12'sd1500 : 12'sd0;
            2:       din <= (((t / DIV) % 15) < 7) ? 12'sd2047 : -12'sd2048;
            3:       din <= 12'($urandom_range(0, 4095));
            default: din <= '0;
        endcase
    end

    task automatic run_samples(input int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic press(input bit up, input bit dn, input int hold);
        btn_up = up; btn_dn = dn;
        repeat (hold) @(negedge clk);
        btn_up = 0; btn_dn = 0;
        repeat (DEB + 6) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(dout == 0, "R9 dout", dout, 0);
        chk(band_idx == 0, "R9 band_idx", band_idx, 0);
        chk(sample_stb == 0, "R9 sample_stb", sample_stb, 0);
        chk(conv_clk == 1, "R9 conv_clk", conv_clk, 1);
        rst = 0;

        mode = 1; run_samples(150);   // R2 impulse response at band 0
        mode = 2; run_samples(250);   // R3 overdrive at resonance
        chk(rails > 0, "R3 saturation reached", rails, 1);

        mode = 3;
        // R7: bouncy press gives one step
        btn_up = 1; @(negedge clk); btn_up = 0; @(negedge clk);
        btn_up = 1; @(negedge clk); btn_up = 0; @(negedge clk);
        press(1, 0, 30);
        run_samples(2);
        chk(band_idx == 1, "R7 bounce one step", band_idx, 1);

        repeat (10) press(1, 0, 20);
        run_samples(2);
        chk(band_idx == 7, "R6 upper stop", band_idx, 7);
        run_samples(80);

        press(1, 1, 20);
        run_samples(2);
        chk(band_idx == 7, "R6 both cancel", band_idx, 7);

        // R7: short glitch on down is ignored
        btn_dn = 1; repeat (4) @(negedge clk); btn_dn = 0;
        run_samples(3);
        chk(band_idx == 7, "R7 glitch ignored", band_idx, 7);

        repeat (10) press(0, 1, 20);
        run_samples(2);
        chk(band_idx == 0, "R6 lower stop", band_idx, 0);

        press(1, 0, 20); press(1, 0, 20);
        run_samples(60);
        chk(band_idx == 2, "R6 two steps", band_idx, 2);

        rst = 1;
        repeat (2) @(negedge clk);
        chk(dout == 0, "R9 mid reset dout", dout, 0);
        chk(band_idx == 0, "R9 mid reset band", band_idx, 0);
        rst = 0;
        run_samples(40);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule